// File: doc/BRIEF.md
# Shareability-Domain Snoop Target Selector

This block sits inside a coherent interconnect. It decides which cache-holding managers must be snooped when one of them issues a read or invalidate request. Each request carries a 2-bit shareability field. The block combines that field with a programmable domain map and returns a per-manager snoop mask, one bit for each manager, plus a flag that says whether any snoop is required.

Every manager has three configuration values: an inner-domain ID, an outer-domain ID and a cache-present enable. The IDs are set independently, so several inner domains can share one outer domain. A mode input selects between two behaviours. In legacy mode, inner-shareable requests snoop only the requester's inner domain. In the newer mode, the inner domain is deprecated and an inner request fans out like an outer one.

The result is registered through a two-state output FSM. ST_IDLE presents no result. ST_RESULT presents the mask computed from the request sampled on the previous edge. The FSM has two transitions: T_ACCEPT is taken whenever `req_valid` is high and leads to ST_RESULT, and T_DRAIN is taken whenever `req_valid` is low and leads to ST_IDLE. Both transitions can start from either state.

Top module: `snoop_domain_sel`

## Requirements
- R1: A request whose domain field is 2'b00 (non-shareable) yields an all-zero snoop mask.
- R2: A request whose domain field is 2'b11 (system) yields an all-zero snoop mask.
- R3: A request whose domain field is 2'b10 (outer) snoops every enabled manager, other than the requester, whose outer ID equals the requester's outer ID.
- R4: With `legacy_mode`=1, a request whose domain field is 2'b01 (inner) snoops only enabled managers, other than the requester, whose inner ID equals the requester's. Managers that share the outer ID but have a different inner ID are not snooped.
- R5: Inner and outer IDs are written independently for each manager, so two or more inner domains can exist inside one outer domain.
- R6: With `legacy_mode`=0, a request with domain 2'b01 produces exactly the mask that a domain 2'b10 request would produce.
- R7: The requester's own bit is always 0 in the snoop mask.
- R8: When `cfg_we`=1, the values on `cfg_inner_id`, `cfg_outer_id` and `cfg_cache_en` are stored for manager `cfg_idx`. A request sampled on the same edge still sees the old map. Requests sampled on later edges see the new map.
- R9: `snp_valid` is high exactly one cycle after a cycle in which `req_valid` was high. While `snp_valid` is low, `snp_mask` is zero.
- R10: `snoop_needed` is 1 exactly when `snp_valid` is 1 and `snp_mask` is non-zero.
- R11: A manager whose enable bit is 0 never appears in any snoop mask.
- R12: After reset, `snp_valid`=0 and `snp_mask`=0, every enable is 0 and every ID is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| legacy_mode | input | 1 | 1: inner requests use the inner map; 0: inner requests are treated as outer |
| cfg_we | input | 1 | Domain map write enable |
| cfg_idx | input | IDX_W | Manager whose entry is written |
| cfg_inner_id | input | ID_W | Inner-domain ID to store |
| cfg_outer_id | input | ID_W | Outer-domain ID to store |
| cfg_cache_en | input | 1 | Cache-present enable to store |
| req_valid | input | 1 | Request present |
| req_src | input | IDX_W | Index of the requesting manager |
| req_domain | input | 2 | Shareability field (00 non, 01 inner, 10 outer, 11 system) |
| snp_valid | output | 1 | Registered result valid |
| snp_mask | output | N_MGR | One bit per manager to snoop |
| snoop_needed | output | 1 | Any bit of the mask is set |

## Verification
A map write and a request can fall in the same clock cycle. When the write changes the requester's peer, the old and new maps give different answers. The bench provokes this by moving a manager to another outer domain in the same cycle as an outer request that would reach it. It expects the result computed from the old map. It then repeats the request one cycle later and expects the result computed from the new map. Output-stage back-to-back requests also overlap a result drain with a new accept, and the bench judges these cases through the vector table.

// File: rtl/snoop_domain_pkg.sv
package snoop_domain_pkg;

    typedef enum logic [1:0] {
        DOM_NONSHARE = 2'b00,
        DOM_INNER    = 2'b01,
        DOM_OUTER    = 2'b10,
        DOM_SYSTEM   = 2'b11
    } share_dom_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_RESULT = 1'b1
    } out_state_e;

endpackage

// File: rtl/snoop_domain_map.sv
module snoop_domain_map #(
    parameter int N_MGR = 4,
    parameter int ID_W  = 2,
    parameter int IDX_W = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [IDX_W-1:0]            wr_idx,
    input  logic [ID_W-1:0]             wr_inner,
    input  logic [ID_W-1:0]             wr_outer,
    input  logic                        wr_cache,
    output logic [N_MGR-1:0][ID_W-1:0]  inner_ids,
    output logic [N_MGR-1:0][ID_W-1:0]  outer_ids,
    output logic [N_MGR-1:0]            cache_en
);

    for (genvar m = 0; m < N_MGR; m++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                inner_ids[m] <= '0;
                outer_ids[m] <= '0;
                cache_en[m]  <= 1'b0;
            end else if (wr_en && (wr_idx == IDX_W'(m))) begin
                inner_ids[m] <= wr_inner;
                outer_ids[m] <= wr_outer;
                cache_en[m]  <= wr_cache;
            end
        end
    end

endmodule

// File: rtl/snoop_mask_calc.sv
module snoop_mask_calc
    import snoop_domain_pkg::*;
#(
    parameter int N_MGR = 4,
    parameter int ID_W  = 2,
    parameter int IDX_W = 2
) (
    input  logic                        legacy_mode,
    input  logic [IDX_W-1:0]            src,
    input  logic [1:0]                  domain,
    input  logic [N_MGR-1:0][ID_W-1:0]  inner_ids,
    input  logic [N_MGR-1:0][ID_W-1:0]  outer_ids,
    input  logic [N_MGR-1:0]            cache_en,
    output logic [N_MGR-1:0]            mask
);

    share_dom_e      dom_eff;
    logic [ID_W-1:0] src_inner;
    logic [ID_W-1:0] src_outer;

    always_comb begin
        dom_eff = share_dom_e'(domain);
        if (dom_eff == DOM_INNER && !legacy_mode) begin
            dom_eff = DOM_OUTER;
        end
    end

    assign src_inner = inner_ids[src];
    assign src_outer = outer_ids[src];

    for (genvar j = 0; j < N_MGR; j++) begin : g_tgt
        logic peer_ok;
        assign peer_ok = cache_en[j] && (src != IDX_W'(j));
        always_comb begin
            unique case (dom_eff)
                DOM_INNER: mask[j] = peer_ok && (inner_ids[j] == src_inner);
                DOM_OUTER: mask[j] = peer_ok && (outer_ids[j] == src_outer);
                default:   mask[j] = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/snoop_domain_sel.sv
module snoop_domain_sel
    import snoop_domain_pkg::*;
#(
    parameter int N_MGR = 4,
    parameter int ID_W  = 2,
    localparam int IDX_W = (N_MGR > 1) ? $clog2(N_MGR) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             legacy_mode,
    input  logic             cfg_we,
    input  logic [IDX_W-1:0] cfg_idx,
    input  logic [ID_W-1:0]  cfg_inner_id,
    input  logic [ID_W-1:0]  cfg_outer_id,
    input  logic             cfg_cache_en,
    input  logic             req_valid,
    input  logic [IDX_W-1:0] req_src,
    input  logic [1:0]       req_domain,
    output logic             snp_valid,
    output logic [N_MGR-1:0] snp_mask,
    output logic             snoop_needed
);

    logic [N_MGR-1:0][ID_W-1:0] inner_ids;
    logic [N_MGR-1:0][ID_W-1:0] outer_ids;
    logic [N_MGR-1:0]           cache_en;
    logic [N_MGR-1:0]           mask_c;
    logic [N_MGR-1:0]           mask_q;
    logic                       need_q;
    out_state_e                 state_q, state_d;

    snoop_domain_map #(.N_MGR(N_MGR), .ID_W(ID_W), .IDX_W(IDX_W)) u_map (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_we),
        .wr_idx    (cfg_idx),
        .wr_inner  (cfg_inner_id),
        .wr_outer  (cfg_outer_id),
        .wr_cache  (cfg_cache_en),
        .inner_ids (inner_ids),
        .outer_ids (outer_ids),
        .cache_en  (cache_en)
    );

    snoop_mask_calc #(.N_MGR(N_MGR), .ID_W(ID_W), .IDX_W(IDX_W)) u_calc (
        .legacy_mode (legacy_mode),
        .src         (req_src),
        .domain      (req_domain),
        .inner_ids   (inner_ids),
        .outer_ids   (outer_ids),
        .cache_en    (cache_en),
        .mask        (mask_c)
    );

    // Next-state: T_ACCEPT on a request, T_DRAIN otherwise
    always_comb begin
        unique case (state_q)
            ST_IDLE:   state_d = req_valid ? ST_RESULT : ST_IDLE;
            ST_RESULT: state_d = req_valid ? ST_RESULT : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State and result register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            mask_q  <= '0;
            need_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            mask_q  <= req_valid ? mask_c : '0;
            need_q  <= req_valid && (mask_c != '0);
        end
    end

    // Outputs from state
    always_comb begin
        unique case (state_q)
            ST_RESULT: begin
                snp_valid    = 1'b1;
                snp_mask     = mask_q;
                snoop_needed = need_q;
            end
            default: begin
                snp_valid    = 1'b0;
                snp_mask     = '0;
                snoop_needed = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/snoop_domain_sel_chk.sv
module snoop_domain_sel_chk #(
    parameter int N_MGR = 4,
    parameter int IDX_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [IDX_W-1:0] req_src,
    input logic [1:0]       req_domain,
    input logic             snp_valid,
    input logic [N_MGR-1:0] snp_mask,
    input logic             snoop_needed,
    input logic [N_MGR-1:0] cache_en
);

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) req_valid |=> snp_valid); // R9
    AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rst_n) !req_valid |=> !snp_valid); // R9
    AST_IDLE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) !snp_valid |-> (snp_mask == '0)); // R9
    AST_NEED_MATCH: assert property (@(posedge clk) disable iff (!rst_n) snoop_needed == (snp_valid && (snp_mask != '0))); // R10
    AST_NONSHARE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && req_domain == 2'b00) |=> (snp_mask == '0)); // R1
    AST_SYSTEM_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && req_domain == 2'b11) |=> (snp_mask == '0)); // R2
    AST_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) req_valid |=> !snp_mask[$past(req_src)]); // R7
    AST_DISABLED_OUT: assert property (@(posedge clk) disable iff (!rst_n) req_valid |=> ((snp_mask & ~$past(cache_en)) == '0)); // R11

endmodule

bind snoop_domain_sel snoop_domain_sel_chk #(.N_MGR(N_MGR), .IDX_W(IDX_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_src      (req_src),
    .req_domain   (req_domain),
    .snp_valid    (snp_valid),
    .snp_mask     (snp_mask),
    .snoop_needed (snoop_needed),
    .cache_en     (cache_en)
);

// File: tb/snoop_domain_sel_tb_top.sv
module snoop_domain_sel_tb_top;

    localparam int N = 4;
    localparam int IW = 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         legacy_mode = 1'b1;
    logic         cfg_we = 1'b0;
    logic [1:0]   cfg_idx = '0;
    logic [IW-1:0] cfg_inner_id = '0;
    logic [IW-1:0] cfg_outer_id = '0;
    logic         cfg_cache_en = 1'b0;
    logic         req_valid = 1'b0;
    logic [1:0]   req_src = '0;
    logic [1:0]   req_domain = '0;
    logic         snp_valid;
    logic [N-1:0] snp_mask;
    logic         snoop_needed;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    snoop_domain_sel #(.N_MGR(N), .ID_W(IW)) dut_i (
        .clk, .rst_n, .legacy_mode, .cfg_we, .cfg_idx, .cfg_inner_id,
        .cfg_outer_id, .cfg_cache_en, .req_valid, .req_src, .req_domain,
        .snp_valid, .snp_mask, .snoop_needed
    );

    // {src[1:0], domain[1:0], legacy, expected mask[3:0]}
    // map: m0 in0/out0, m1 in0/out0, m2 in1/out0, m3 in2/out1
    localparam logic [8:0] VEC [12] = '{
        {2'd0, 2'b00, 1'b1, 4'b0000},  // R1
        {2'd0, 2'b11, 1'b1, 4'b0000},  // R2
        {2'd0, 2'b10, 1'b1, 4'b0110},  // R3
        {2'd0, 2'b01, 1'b1, 4'b0010},  // R4
        {2'd2, 2'b01, 1'b1, 4'b0000},  // R4 R5
        {2'd2, 2'b10, 1'b1, 4'b0011},  // R3 R5
        {2'd3, 2'b10, 1'b1, 4'b0000},  // R3
        {2'd1, 2'b01, 1'b1, 4'b0001},  // R4
        {2'd0, 2'b01, 1'b0, 4'b0110},  // R6
        {2'd2, 2'b01, 1'b0, 4'b0011},  // R6
        {2'd3, 2'b01, 1'b0, 4'b0000},  // R6
        {2'd1, 2'b10, 1'b1, 4'b0101}   // R3 R7
    };

    task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] idx, input logic [IW-1:0] inr,
                             input logic [IW-1:0] outr, input logic en);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = idx; cfg_inner_id = inr;
        cfg_outer_id = outr; cfg_cache_en = en;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // drive at negedge, result registered at next posedge, sampled at following negedge
    task automatic do_req(input logic [1:0] src, input logic [1:0] dom, input logic leg,
                          input logic [N-1:0] exp, input string tag);
        req_valid = 1'b1; req_src = src; req_domain = dom; legacy_mode = leg;
        @(negedge clk);
        req_valid = 1'b0;
        check({tag, " mask"}, snp_mask, exp);
        check({tag, " R9 valid"}, {3'b0, snp_valid}, 4'b0001);
        check({tag, " R10 need"}, {3'b0, snoop_needed}, {3'b0, |exp});
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=done");
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R12 reset valid", {3'b0, snp_valid}, 4'b0000);
        check("R12 reset mask", snp_mask, 4'b0000);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 R12: all enables reset to 0, so outer request reaches nobody
        do_req(2'd0, 2'b10, 1'b1, 4'b0000, "R12 R11 post-reset");

        cfg_write(2'd0, 2'd0, 2'd0, 1'b1);   // R5 R8
        cfg_write(2'd1, 2'd0, 2'd0, 1'b1);
        cfg_write(2'd2, 2'd1, 2'd0, 1'b1);
        cfg_write(2'd3, 2'd2, 2'd1, 1'b1);

        // vector table, back to back
        @(negedge clk);
        for (int i = 0; i < 12; i++) begin
            do_req(VEC[i][8:7], VEC[i][6:5], VEC[i][4], VEC[i][3:0], $sformatf("vec%0d R1-R7", i));
        end
        @(negedge clk);
        check("R9 drain valid", {3'b0, snp_valid}, 4'b0000);
        check("R9 drain mask", snp_mask, 4'b0000);

        // R11: disable m1
        cfg_write(2'd1, 2'd0, 2'd0, 1'b0);
        do_req(2'd0, 2'b10, 1'b1, 4'b0100, "R11 disabled m1");
        do_req(2'd0, 2'b01, 1'b1, 4'b0000, "R11 inner disabled");

        // R8: same-cycle write moves m2 to outer 1; request sees old map
        cfg_we = 1'b1; cfg_idx = 2'd2; cfg_inner_id = 2'd1;
        cfg_outer_id = 2'd1; cfg_cache_en = 1'b1;
        req_valid = 1'b1; req_src = 2'd0; req_domain = 2'b10; legacy_mode = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0; req_valid = 1'b0;
        check("R8 same-cycle old map", snp_mask, 4'b0100);
        do_req(2'd0, 2'b10, 1'b1, 4'b0000, "R8 new map");
        do_req(2'd3, 2'b10, 1'b1, 4'b0100, "R8 R3 new peer");
        // R7: requester is the only match
        do_req(2'd2, 2'b01, 1'b1, 4'b0000, "R7 lone requester");

        done = 1'b1;
        summary();
    end

endmodule